// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the fields of the current instruction word into every steering and enable signal that a one-instruction-per-clock datapath needs. It looks at the 6-bit major opcode and the 6-bit function code. It also sees the zero flag from the arithmetic unit and two already-synchronized request lines, one for reset and one for interrupt. From these it drives the next-PC choice, the immediate extension mode and the register-file destination and source of write data. It also drives the arithmetic function, both operand muxes and the two write enables. It is purely combinational and sits between the instruction memory output and the datapath muxes.

Decoding is exact. Each legal opcode and function value is matched bit for bit, and anything else becomes an illegal-instruction trap. The trap redirects the PC and saves the return address in register 27. Reset takes precedence over interrupt, and interrupt takes precedence over decode. The block has no data stream of its own, so it has no valid/ready handshake. All its pins are plain control levels that settle within the same cycle.

Top module: `ctl_decoder`

## Requirements
- R1: While `rst_req` is 1, `pc_sel` is 6 (reset vector), `rf_we` and `mem_we` are 0, and every other output holds its default, whatever the other inputs are.
- R2: With `rst_req` 0 and `irq_req` 1, `pc_sel` is 5 (interrupt vector), `wa_sel` is 3 (register 27), `wd_sel` is 2 (PC+4), `rf_we` is 1, `mem_we` is 0, and the remaining outputs hold defaults.
- R3: Any opcode or register-type function code not listed in R4 to R12 gives `pc_sel` 4 (illegal vector), `wa_sel` 3, `wd_sel` 2, `rf_we` 1, `mem_we` 0, and defaults elsewhere. The legal opcodes are 000000, 000010, 000011, 000100, 000101, 001000 to 001111, 100011 and 101011.
- R4: For opcode 000000, the function codes map to `alu_fn` as follows: 100000 and 100001 give ADD (0), 100010 and 100011 give SUB (1), 101010 gives SLT (2), 101011 gives SLTU (3), 100100 gives AND (8), 100101 gives OR (9), 100110 gives XOR (10) and 100111 gives NOR (11). Each writes rd (`wa_sel` 0) with the ALU result (`wd_sel` 0), with both operands from registers (`a_sel` 0, `b_sel` 0).
- R5: Function codes 000000, 000010 and 000011 are constant shifts. They take the shift amount from the shamt field (`a_sel` 1). Codes 000100, 000110 and 000111 are variable shifts with the amount from rs (`a_sel` 0). Low bits 00, 10 and 11 select SLL (16), SRL (17) and SRA (18). All six write rd.
- R6: Function code 001000 (register jump) sets `pc_sel` 3 and writes nothing. Code 001001 (register jump and link) sets `pc_sel` 3 and writes rd with PC+4 (`wd_sel` 2).
- R7: Opcodes 001000 to 001110 write rt (`wa_sel` 1) from the ALU, with `b_sel` 1 (immediate). Their low three bits 000/001, 010, 011, 100, 101 and 110 give ADD, SLT, SLTU, AND, OR and XOR. `sext_en` is 0 only for 001100, 001101 and 001110, and 1 for every other input.
- R8: Opcode 001111 (load upper) sets `a_sel` 2 (constant 16), `b_sel` 1 and `alu_fn` SLL, and writes rt from the ALU.
- R9: Opcode 100011 (load) sets `alu_fn` ADD, `b_sel` 1 and `wd_sel` 1 (memory), and writes rt.
- R10: Opcode 101011 (store) sets `mem_we` 1, `rf_we` 0, `b_sel` 1 and `alu_fn` ADD. No other input combination asserts `mem_we`.
- R11: Opcode 000100 takes the branch (`pc_sel` 1) when `alu_zero` is 1, and opcode 000101 takes it when `alu_zero` is 0; otherwise `pc_sel` is 0. Both use `alu_fn` SUB with `b_sel` 0 and write nothing.
- R12: Opcodes 000010 and 000011 set `pc_sel` 2 (jump target). Only 000011 writes, putting PC+4 into register 31 (`wa_sel` 2, `wd_sel` 2).
- R13: Defaults, used by any field the rules above leave unset, are `pc_sel` 0, `sext_en` 1, `wa_sel` 0, `wd_sel` 0, `alu_fn` ADD, `a_sel` 0, `b_sel` 0, `rf_we` 0 and `mem_we` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_req | input | 1 | Synchronized reset request, highest priority |
| irq_req | input | 1 | Synchronized interrupt request |
| opcode | input | 6 | Major opcode field of the instruction |
| funct | input | 6 | Function code field of the instruction |
| alu_zero | input | 1 | Zero flag of the current ALU result |
| pc_sel | output | 3 | Next-PC source |
| sext_en | output | 1 | 1 = sign-extend immediate, 0 = zero-extend |
| wa_sel | output | 2 | Destination register: rd, rt, 31, 27 |
| wd_sel | output | 2 | Write data: ALU, memory, PC+4 |
| alu_fn | output | 5 | ALU operation code |
| mem_we | output | 1 | Data memory write enable |
| rf_we | output | 1 | Register file write enable |
| a_sel | output | 2 | A operand: rs, shamt, constant 16 |
| b_sel | output | 1 | B operand: rt or extended immediate |

## Verification
The field widths are fixed package constants, and the bench builds the block with those defaults. Both 6-bit fields are small, so the bench sweeps every opcode against every function code with the zero flag both ways. That reaches every exact-match decision and every illegal pattern, including the near-miss codes such as 000001 and 000101 inside the shift group. A seeded random phase then mixes reset and interrupt requests into arbitrary instruction words to exercise the priority order.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int ALUFN_W = 5;
  localparam int PCSEL_W = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [PCSEL_W-1:0] {
    PC_NEXT    = 3'd0,
    PC_BRANCH  = 3'd1,
    PC_JUMP    = 3'd2,
    PC_REG     = 3'd3,
    PC_ILLEGAL = 3'd4,
    PC_IRQ     = 3'd5,
    PC_RESET   = 3'd6
  } pc_sel_e;

  typedef enum logic [SEL_W-1:0] {
    WA_RD   = 2'd0,
    WA_RT   = 2'd1,
    WA_LINK = 2'd2,
    WA_TRAP = 2'd3
  } wa_sel_e;

  typedef enum logic [SEL_W-1:0] {
    WD_ALU  = 2'd0,
    WD_MEM  = 2'd1,
    WD_LINK = 2'd2
  } wd_sel_e;

  typedef enum logic [SEL_W-1:0] {
    A_REG     = 2'd0,
    A_SHAMT   = 2'd1,
    A_SIXTEEN = 2'd2
  } a_sel_e;

  typedef enum logic {
    B_REG = 1'b0,
    B_IMM = 1'b1
  } b_sel_e;

  typedef enum logic [ALUFN_W-1:0] {
    FN_ADD  = 5'd0,
    FN_SUB  = 5'd1,
    FN_SLT  = 5'd2,
    FN_SLTU = 5'd3,
    FN_AND  = 5'd8,
    FN_OR   = 5'd9,
    FN_XOR  = 5'd10,
    FN_NOR  = 5'd11,
    FN_SLL  = 5'd16,
    FN_SRL  = 5'd17,
    FN_SRA  = 5'd18
  } alu_fn_e;

  typedef enum logic [3:0] {
    K_ALU_R,
    K_SHIFT_C,
    K_SHIFT_V,
    K_JR,
    K_JALR,
    K_ALU_I,
    K_LUI,
    K_LOAD,
    K_STORE,
    K_BEQ,
    K_BNE,
    K_J,
    K_JAL,
    K_ILLEGAL
  } kind_e;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_J     = 6'b000010;
  localparam logic [OPC_W-1:0] OP_JAL   = 6'b000011;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OP_BNE   = 6'b000101;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'b001000;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'b001001;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'b001010;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'b001011;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OP_XORI  = 6'b001110;
  localparam logic [OPC_W-1:0] OP_LUI   = 6'b001111;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;

  localparam logic [FN_W-1:0] F_SLL  = 6'b000000;
  localparam logic [FN_W-1:0] F_SRL  = 6'b000010;
  localparam logic [FN_W-1:0] F_SRA  = 6'b000011;
  localparam logic [FN_W-1:0] F_SLLV = 6'b000100;
  localparam logic [FN_W-1:0] F_SRLV = 6'b000110;
  localparam logic [FN_W-1:0] F_SRAV = 6'b000111;
  localparam logic [FN_W-1:0] F_JR   = 6'b001000;
  localparam logic [FN_W-1:0] F_JALR = 6'b001001;
  localparam logic [FN_W-1:0] F_ADD  = 6'b100000;
  localparam logic [FN_W-1:0] F_ADDU = 6'b100001;
  localparam logic [FN_W-1:0] F_SUB  = 6'b100010;
  localparam logic [FN_W-1:0] F_SUBU = 6'b100011;
  localparam logic [FN_W-1:0] F_AND  = 6'b100100;
  localparam logic [FN_W-1:0] F_OR   = 6'b100101;
  localparam logic [FN_W-1:0] F_XOR  = 6'b100110;
  localparam logic [FN_W-1:0] F_NOR  = 6'b100111;
  localparam logic [FN_W-1:0] F_SLT  = 6'b101010;
  localparam logic [FN_W-1:0] F_SLTU = 6'b101011;

endpackage

// File: rtl/ctl_op_classify.sv
module ctl_op_classify
  import ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output kind_e            kind
);

  kind_e rtype_kind;

  // exact match of every register-type function code
  always_comb begin
    unique case (funct)
      F_SLL, F_SRL, F_SRA:                 rtype_kind = K_SHIFT_C;
      F_SLLV, F_SRLV, F_SRAV:              rtype_kind = K_SHIFT_V;
      F_JR:                                rtype_kind = K_JR;
      F_JALR:                              rtype_kind = K_JALR;
      F_ADD, F_ADDU, F_SUB, F_SUBU,
      F_AND, F_OR, F_XOR, F_NOR,
      F_SLT, F_SLTU:                       rtype_kind = K_ALU_R;
      default:                             rtype_kind = K_ILLEGAL;
    endcase
  end

  always_comb begin
    unique case (opcode)
      OP_RTYPE:                            kind = rtype_kind;
      OP_J:                                kind = K_J;
      OP_JAL:                              kind = K_JAL;
      OP_BEQ:                              kind = K_BEQ;
      OP_BNE:                              kind = K_BNE;
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
      OP_ANDI, OP_ORI, OP_XORI:            kind = K_ALU_I;
      OP_LUI:                              kind = K_LUI;
      OP_LOAD:                             kind = K_LOAD;
      OP_STORE:                            kind = K_STORE;
      default:                             kind = K_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/ctl_alu_decode.sv
module ctl_alu_decode
  import ctl_pkg::*;
(
  input  kind_e            kind,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output alu_fn_e          alu_fn,
  output logic             sext_en
);

  alu_fn_e fn_rtype;
  alu_fn_e fn_shift;
  alu_fn_e fn_imm;

  always_comb begin
    case (funct)
      F_SUB, F_SUBU: fn_rtype = FN_SUB;
      F_AND:         fn_rtype = FN_AND;
      F_OR:          fn_rtype = FN_OR;
      F_XOR:         fn_rtype = FN_XOR;
      F_NOR:         fn_rtype = FN_NOR;
      F_SLT:         fn_rtype = FN_SLT;
      F_SLTU:        fn_rtype = FN_SLTU;
      default:       fn_rtype = FN_ADD;
    endcase
  end

  // shift direction/kind is shared by constant and variable forms
  always_comb begin
    case (funct)
      F_SRL, F_SRLV: fn_shift = FN_SRL;
      F_SRA, F_SRAV: fn_shift = FN_SRA;
      default:       fn_shift = FN_SLL;
    endcase
  end

  always_comb begin
    case (opcode)
      OP_SLTI:  fn_imm = FN_SLT;
      OP_SLTIU: fn_imm = FN_SLTU;
      OP_ANDI:  fn_imm = FN_AND;
      OP_ORI:   fn_imm = FN_OR;
      OP_XORI:  fn_imm = FN_XOR;
      default:  fn_imm = FN_ADD;
    endcase
  end

  always_comb begin
    alu_fn  = FN_ADD;
    sext_en = 1'b1;
    unique case (kind)
      K_ALU_R:              alu_fn = fn_rtype;
      K_SHIFT_C, K_SHIFT_V: alu_fn = fn_shift;
      K_ALU_I: begin
        alu_fn  = fn_imm;
        sext_en = !(opcode == OP_ANDI || opcode == OP_ORI || opcode == OP_XORI);
      end
      K_LUI:                alu_fn = FN_SLL;
      K_BEQ, K_BNE:         alu_fn = FN_SUB;
      default:              alu_fn = FN_ADD;
    endcase
  end

endmodule

// File: rtl/ctl_path_decode.sv
module ctl_path_decode
  import ctl_pkg::*;
(
  input  kind_e   kind,
  input  logic    alu_zero,
  output pc_sel_e pc_sel,
  output wa_sel_e wa_sel,
  output wd_sel_e wd_sel,
  output a_sel_e  a_sel,
  output b_sel_e  b_sel,
  output logic    mem_we,
  output logic    rf_we
);

  always_comb begin
    pc_sel = PC_NEXT;
    wa_sel = WA_RD;
    wd_sel = WD_ALU;
    a_sel  = A_REG;
    b_sel  = B_REG;
    mem_we = 1'b0;
    rf_we  = 1'b0;
    unique case (kind)
      K_ALU_R, K_SHIFT_V: rf_we = 1'b1;
      K_SHIFT_C: begin
        rf_we = 1'b1;
        a_sel = A_SHAMT;
      end
      K_JR:   pc_sel = PC_REG;
      K_JALR: begin
        pc_sel = PC_REG;
        wd_sel = WD_LINK;
        rf_we  = 1'b1;
      end
      K_ALU_I: begin
        wa_sel = WA_RT;
        b_sel  = B_IMM;
        rf_we  = 1'b1;
      end
      K_LUI: begin
        wa_sel = WA_RT;
        a_sel  = A_SIXTEEN;
        b_sel  = B_IMM;
        rf_we  = 1'b1;
      end
      K_LOAD: begin
        wa_sel = WA_RT;
        wd_sel = WD_MEM;
        b_sel  = B_IMM;
        rf_we  = 1'b1;
      end
      K_STORE: begin
        b_sel  = B_IMM;
        mem_we = 1'b1;
      end
      K_BEQ: pc_sel = alu_zero ? PC_BRANCH : PC_NEXT;
      K_BNE: pc_sel = alu_zero ? PC_NEXT : PC_BRANCH;
      K_J:   pc_sel = PC_JUMP;
      K_JAL: begin
        pc_sel = PC_JUMP;
        wa_sel = WA_LINK;
        wd_sel = WD_LINK;
        rf_we  = 1'b1;
      end
      default: begin
        pc_sel = PC_ILLEGAL;
        wa_sel = WA_TRAP;
        wd_sel = WD_LINK;
        rf_we  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic               rst_req,
  input  logic               irq_req,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FN_W-1:0]    funct,
  input  logic               alu_zero,
  output logic [PCSEL_W-1:0] pc_sel,
  output logic               sext_en,
  output logic [SEL_W-1:0]   wa_sel,
  output logic [SEL_W-1:0]   wd_sel,
  output logic [ALUFN_W-1:0] alu_fn,
  output logic               mem_we,
  output logic               rf_we,
  output logic [SEL_W-1:0]   a_sel,
  output logic               b_sel
);

  kind_e   kind;
  alu_fn_e dec_fn;
  logic    dec_sext;
  pc_sel_e dec_pc;
  wa_sel_e dec_wa;
  wd_sel_e dec_wd;
  a_sel_e  dec_a;
  b_sel_e  dec_b;
  logic    dec_mw;
  logic    dec_rw;

  ctl_op_classify u_classify (
    .opcode (opcode),
    .funct  (funct),
    .kind   (kind)
  );

  ctl_alu_decode u_alu (
    .kind    (kind),
    .opcode  (opcode),
    .funct   (funct),
    .alu_fn  (dec_fn),
    .sext_en (dec_sext)
  );

  ctl_path_decode u_path (
    .kind     (kind),
    .alu_zero (alu_zero),
    .pc_sel   (dec_pc),
    .wa_sel   (dec_wa),
    .wd_sel   (dec_wd),
    .a_sel    (dec_a),
    .b_sel    (dec_b),
    .mem_we   (dec_mw),
    .rf_we    (dec_rw)
  );

  // priority: reset, then interrupt, then the decoded instruction
  always_comb begin
    if (rst_req) begin
      pc_sel  = PC_RESET;
      sext_en = 1'b1;
      wa_sel  = WA_RD;
      wd_sel  = WD_ALU;
      alu_fn  = FN_ADD;
      mem_we  = 1'b0;
      rf_we   = 1'b0;
      a_sel   = A_REG;
      b_sel   = B_REG;
    end else if (irq_req) begin
      pc_sel  = PC_IRQ;
      sext_en = 1'b1;
      wa_sel  = WA_TRAP;
      wd_sel  = WD_LINK;
      alu_fn  = FN_ADD;
      mem_we  = 1'b0;
      rf_we   = 1'b1;
      a_sel   = A_REG;
      b_sel   = B_REG;
    end else begin
      pc_sel  = dec_pc;
      sext_en = dec_sext;
      wa_sel  = dec_wa;
      wd_sel  = dec_wd;
      alu_fn  = dec_fn;
      mem_we  = dec_mw;
      rf_we   = dec_rw;
      a_sel   = dec_a;
      b_sel   = dec_b;
    end
  end

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
  import ctl_pkg::*;
(
  input logic               rst_req,
  input logic               irq_req,
  input logic [OPC_W-1:0]   opcode,
  input logic [FN_W-1:0]    funct,
  input logic               alu_zero,
  input logic [PCSEL_W-1:0] pc_sel,
  input logic               sext_en,
  input logic [SEL_W-1:0]   wa_sel,
  input logic [SEL_W-1:0]   wd_sel,
  input logic [ALUFN_W-1:0] alu_fn,
  input logic               mem_we,
  input logic               rf_we,
  input logic [SEL_W-1:0]   a_sel,
  input logic               b_sel
);

  always_comb begin
    // R1
    reset_quiet_chk: assert (!rst_req || (pc_sel == 3'd6 && !rf_we && !mem_we));
    // R2
    irq_trap_chk: assert (rst_req || !irq_req ||
                          (pc_sel == 3'd5 && wa_sel == 2'd3 && wd_sel == 2'd2 && rf_we && !mem_we));
    // R10
    store_only_mem_chk: assert (!mem_we || (opcode == 6'b101011 && !rst_req && !irq_req && !rf_we));
    // R12
    jump_target_chk: assert (pc_sel != 3'd2 || opcode[5:1] == 5'b00001);
    // R9
    mem_wb_chk: assert (wd_sel != 2'd1 || (opcode == 6'b100011 && rf_we));
    // R8
    sixteen_chk: assert (a_sel != 2'd2 || (opcode == 6'b001111 && alu_fn == 5'd16));
    // R11
    branch_flag_chk: assert (pc_sel != 3'd1 ||
                             (opcode == 6'b000100 && alu_zero) || (opcode == 6'b000101 && !alu_zero));
    // R7
    zero_ext_chk: assert (sext_en || (opcode[5:2] == 4'b0011 && opcode[1:0] != 2'b11));
    // R5
    shamt_chk: assert (a_sel != 2'd1 || (opcode == 6'b000000 && funct[5:2] == 4'b0000));
  end

endmodule

bind ctl_decoder ctl_decoder_chk u_chk (
  .rst_req  (rst_req),
  .irq_req  (irq_req),
  .opcode   (opcode),
  .funct    (funct),
  .alu_zero (alu_zero),
  .pc_sel   (pc_sel),
  .sext_en  (sext_en),
  .wa_sel   (wa_sel),
  .wd_sel   (wd_sel),
  .alu_fn   (alu_fn),
  .mem_we   (mem_we),
  .rf_we    (rf_we),
  .a_sel    (a_sel),
  .b_sel    (b_sel)
);

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_req, irq_req, alu_zero;
  logic [5:0] opcode, funct;
  logic [2:0] pc_sel;
  logic       sext_en, mem_we, rf_we, b_sel;
  logic [1:0] wa_sel, wd_sel, a_sel;
  logic [4:0] alu_fn;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ctl_decoder u_dut (
    .rst_req (rst_req), .irq_req (irq_req), .opcode (opcode), .funct (funct),
    .alu_zero(alu_zero), .pc_sel (pc_sel), .sext_en (sext_en), .wa_sel (wa_sel),
    .wd_sel  (wd_sel), .alu_fn (alu_fn), .mem_we (mem_we), .rf_we (rf_we),
    .a_sel   (a_sel), .b_sel (b_sel)
  );

  // packing: {pc(3), sext(1), wa(2), wd(2), alu(5), mw(1), rw(1), a(2), b(1)}
  function automatic logic [17:0] pack(logic [2:0] pc, logic sx, logic [1:0] wa, logic [1:0] wd,
                                       logic [4:0] fn, logic mw, logic rw, logic [1:0] as, logic bs);
    return {pc, sx, wa, wd, fn, mw, rw, as, bs};
  endfunction

  function automatic logic [17:0] expect_ctl(logic [5:0] op, logic [5:0] fn, logic z,
                                             logic rst, logic irq, output string tag);
    logic [2:0] pc = 3'd0; logic sx = 1'b1; logic [1:0] wa = 2'd0; logic [1:0] wd = 2'd0;
    logic [4:0] af = 5'd0; logic mw = 1'b0; logic rw = 1'b0; logic [1:0] as = 2'd0;
    logic bs = 1'b0; logic bad = 1'b0;
    tag = "R13";
    if (rst) begin
      pc = 3'd6; tag = "R1";
    end else if (irq) begin
      pc = 3'd5; wa = 2'd3; wd = 2'd2; rw = 1'b1; tag = "R2";
    end else begin
      case (op)
        6'd0: begin
          case (fn)
            6'd0, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7: begin
              rw = 1'b1; tag = "R5";
              as = fn[2] ? 2'd0 : 2'd1;
              af = (fn[1:0] == 2'b00) ? 5'd16 : (fn[1:0] == 2'b10) ? 5'd17 : 5'd18;
            end
            6'd8: begin pc = 3'd3; tag = "R6"; end
            6'd9: begin pc = 3'd3; rw = 1'b1; wd = 2'd2; tag = "R6"; end
            6'd32, 6'd33: begin rw = 1'b1; af = 5'd0;  tag = "R4"; end
            6'd34, 6'd35: begin rw = 1'b1; af = 5'd1;  tag = "R4"; end
            6'd36:        begin rw = 1'b1; af = 5'd8;  tag = "R4"; end
            6'd37:        begin rw = 1'b1; af = 5'd9;  tag = "R4"; end
            6'd38:        begin rw = 1'b1; af = 5'd10; tag = "R4"; end
            6'd39:        begin rw = 1'b1; af = 5'd11; tag = "R4"; end
            6'd42:        begin rw = 1'b1; af = 5'd2;  tag = "R4"; end
            6'd43:        begin rw = 1'b1; af = 5'd3;  tag = "R4"; end
            default: bad = 1'b1;
          endcase
        end
        6'd8, 6'd9, 6'd10, 6'd11, 6'd12, 6'd13, 6'd14: begin
          rw = 1'b1; wa = 2'd1; bs = 1'b1; tag = "R7";
          case (op[2:0])
            3'd2: af = 5'd2;
            3'd3: af = 5'd3;
            3'd4: begin af = 5'd8;  sx = 1'b0; end
            3'd5: begin af = 5'd9;  sx = 1'b0; end
            3'd6: begin af = 5'd10; sx = 1'b0; end
            default: af = 5'd0;
          endcase
        end
        6'd15: begin rw = 1'b1; wa = 2'd1; bs = 1'b1; as = 2'd2; af = 5'd16; tag = "R8"; end
        6'd35: begin rw = 1'b1; wa = 2'd1; wd = 2'd1; bs = 1'b1; tag = "R9"; end
        6'd43: begin mw = 1'b1; bs = 1'b1; tag = "R10"; end
        6'd4:  begin af = 5'd1; pc = z ? 3'd1 : 3'd0; tag = "R11"; end
        6'd5:  begin af = 5'd1; pc = z ? 3'd0 : 3'd1; tag = "R11"; end
        6'd2:  begin pc = 3'd2; tag = "R12"; end
        6'd3:  begin pc = 3'd2; rw = 1'b1; wa = 2'd2; wd = 2'd2; tag = "R12"; end
        default: bad = 1'b1;
      endcase
      if (bad) begin
        pc = 3'd4; wa = 2'd3; wd = 2'd2; rw = 1'b1; tag = "R3";
      end
    end
    return pack(pc, sx, wa, wd, af, mw, rw, as, bs);
  endfunction

  task automatic apply_check(logic [5:0] op, logic [5:0] fn, logic z, logic rst, logic irq);
    logic [17:0] exp_v, got_v;
    string tag;
    @(posedge clk);
    opcode = op; funct = fn; alu_zero = z; rst_req = rst; irq_req = irq;
    @(negedge clk);
    exp_v = expect_ctl(op, fn, z, rst, irq, tag);
    got_v = pack(pc_sel, sext_en, wa_sel, wd_sel, alu_fn, mem_we, rf_we, a_sel, b_sel);
    n_run++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%b fn=%b z=%b rst=%b irq=%b got=%h expected=%h",
               tag, op, fn, z, rst, irq, got_v, exp_v);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0411));
    rst_req = 1'b1; irq_req = 1'b0; opcode = '0; funct = '0; alu_zero = 1'b0;
    // R1 reset state, even with a store and an interrupt pending
    apply_check(6'b000000, 6'b100000, 1'b0, 1'b1, 1'b0);
    apply_check(6'b101011, 6'b000000, 1'b1, 1'b1, 1'b1);
    // R2 interrupt beats an illegal opcode and a store
    apply_check(6'b111111, 6'b000000, 1'b0, 1'b0, 1'b1);
    apply_check(6'b101011, 6'b000000, 1'b0, 1'b0, 1'b1);
    // R3 near-miss codes inside legal groups
    apply_check(6'b000000, 6'b000001, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000000, 6'b000101, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000000, 6'b101100, 1'b0, 1'b0, 1'b0);
    apply_check(6'b100001, 6'b000000, 1'b0, 1'b0, 1'b0);
    // R4 R5 R6 directed
    apply_check(6'b000000, 6'b101011, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000000, 6'b000011, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000000, 6'b000110, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000000, 6'b001001, 1'b0, 1'b0, 1'b0);
    // R7 R8 R9 R10: zero-extend, load upper, load, store
    apply_check(6'b001101, 6'b111111, 1'b0, 1'b0, 1'b0);
    apply_check(6'b001111, 6'b000000, 1'b0, 1'b0, 1'b0);
    apply_check(6'b100011, 6'b000000, 1'b0, 1'b0, 1'b0);
    apply_check(6'b101011, 6'b100000, 1'b0, 1'b0, 1'b0);
    // R11 both branches, both flag values
    apply_check(6'b000100, 6'b000000, 1'b1, 1'b0, 1'b0);
    apply_check(6'b000100, 6'b000000, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000101, 6'b000000, 1'b1, 1'b0, 1'b0);
    apply_check(6'b000101, 6'b000000, 1'b0, 1'b0, 1'b0);
    // R12 jumps
    apply_check(6'b000010, 6'b000000, 1'b0, 1'b0, 1'b0);
    apply_check(6'b000011, 6'b000000, 1'b0, 1'b0, 1'b0);
    // R13 defaults and every other rule: full sweep of opcode x function x flag
    for (int op = 0; op < 64; op++)
      for (int fn = 0; fn < 64; fn++)
        for (int z = 0; z < 2; z++)
          apply_check(6'(op), 6'(fn), 1'(z), 1'b0, 1'b0);
    // R1 R2 priority under random words
    for (int i = 0; i < 3000; i++)
      apply_check(6'($urandom), 6'($urandom), 1'($urandom),
                  ($urandom % 8) == 0, ($urandom % 4) == 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule